// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host-side master for a 12-bit successive-approximation converter that has a three-wire serial port. It drives the active-low chip-select and the serial clock, and it samples the converter's data line. Each completed conversion frame delivers one 12-bit straight-binary result on a parallel valid/ready output. The serial clock comes from the system clock. Each half period lasts a programmable number of system clocks, so the high and low phases are always equal. Between frames, chip-select stays high for a programmable number of system clocks.

The block does power management through frame length alone. A sleep command runs a frame that is cut short: chip-select rises after a small, fixed number of falling clock edges, inside the window the converter treats as a power-down request. A wake command runs a full 16-edge dummy frame and throws its data away. Normal frames last either 14 or 16 clock cycles. The two leading bits of a normal frame are checked, and a non-zero leading bit is reported as a framing error beside the result. The two trailing zeros of a 16-cycle frame are captured but not used.

The controller has five states. IDLE waits with chip-select high and decides which frame to start. SETUP holds chip-select low with the clock low for one half period. HIGH and LOW alternate the clock phases. GAP holds chip-select high after a frame. The transitions are:
- start (IDLE to SETUP): wake has priority over sleep, and sleep has priority over a normal frame.
- first-rise (SETUP to HIGH).
- fall (HIGH to LOW): taken when more falling edges remain.
- end-of-frame (HIGH to GAP): taken on the last falling edge.
- rise (LOW to HIGH).
- gap-done (GAP to IDLE).

Configuration is latched only on the start transition.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, chip-select is high, the serial clock is low, result-valid is low and the asleep flag is low.
- R2: A normal frame has 16 rising and 16 falling clock edges when cfg_len16 is 1, and 14 of each when it is 0. Chip-select stays low for exactly 2·N·H system clocks, where N is the edge count and H is cfg_half_div (a value of 0 counts as 1).
- R3: The data line is sampled on each rising clock edge. Captured bits 3 to 14 form the result, most significant bit first, as straight binary.
- R4: The serial clock is low while chip-select is high. Its first rise comes H system clocks after chip-select falls, and every high phase and every low phase lasts exactly H system clocks.
- R5: A result stays valid, with unchanged data, until result-ready is sampled high. While a result is pending and cfg_overwrite is 0, no normal frame starts.
- R6: When cfg_overwrite is 1, normal frames continue while a result is pending. Each finished frame replaces the data with the newest result and valid stays high.
- R7: In continuous operation, chip-select stays high for G+1 system clocks between frames, where G is cfg_gap (a value of 0 counts as 1).
- R8: cmd_sleep while awake runs a frame of SLEEP_EDGES falling edges (4 by default; it must lie between 2 and 10). That frame produces no result and sets the asleep flag.
- R9: While asleep, neither run nor cmd_sleep starts a frame.
- R10: cmd_wake while asleep runs a 16-edge frame that produces no result and clears the asleep flag. Normal frames can then follow.
- R11: The framing-error output is 1 with a result if either of the first two captured bits was 1, and 0 otherwise.
- R12: cfg_half_div, cfg_len16 and cfg_gap are sampled only at frame start. A change during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Request continuous normal frames |
| cmd_sleep | input | 1 | Level request for a sleep frame |
| cmd_wake | input | 1 | Level request for a wake frame |
| cfg_half_div | input | DIV_W | Serial clock half period in system clocks |
| cfg_len16 | input | 1 | 1: 16-cycle frame, 0: 14-cycle frame |
| cfg_gap | input | GAP_W | Chip-select high time between frames, in system clocks |
| cfg_overwrite | input | 1 | Allow a new result to replace a pending one |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_csn | output | 1 | Active-low chip-select to the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| res_data | output | DATA_W | Conversion result |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_frame_err | output | 1 | Leading bits of this result were not zero |
| asleep | output | 1 | Converter has been commanded into sleep |

## Verification
The assertions assume that the converter only changes its data line on a chip-select fall or a falling clock edge. They also assume that a consumer holding result-ready low leaves the result untouched.

The bench meets these assumptions with a behavioural converter model that updates its data line only on those events. All command and configuration inputs are changed at falling system-clock edges. Sleep and wake are held as level requests until the frame they trigger has started. The mid-frame configuration change in R12 happens while chip-select is low, which is the condition the latching rule is meant to cover.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_GAP
    } rd_state_e;

    typedef enum logic [1:0] {
        FK_NORMAL,
        FK_SLEEP,
        FK_WAKE
    } frame_kind_e;

endpackage

// File: rtl/adcrd_timer.sv
module adcrd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expire
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (val == '0) ? W'(1) : val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expire = (cnt_q == W'(1));

    // R4: phase length comes from an uninterrupted count-down
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q > W'(1)) |=> (cnt_q == $past(cnt_q) - W'(1)));

endmodule

// File: rtl/adcrd_capture.sv
module adcrd_capture #(
    parameter int DATA_W = 12,
    parameter int LEAD_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              stb,
    input  logic              sdi,
    output logic [DATA_W-1:0] data,
    output logic              lead_bad
);

    localparam int USED  = LEAD_N + DATA_W;
    localparam int IDX_W = $clog2(USED + 1);

    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] data_q;
    logic              bad_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            data_q <= '0;
            bad_q  <= 1'b0;
        end else if (clr) begin
            idx_q  <= '0;
            data_q <= '0;
            bad_q  <= 1'b0;
        end else if (stb) begin
            if (idx_q < IDX_W'(LEAD_N)) begin
                bad_q <= bad_q | sdi;
            end else if (idx_q < IDX_W'(USED)) begin
                data_q <= {data_q[DATA_W-2:0], sdi};
            end
            if (idx_q != IDX_W'(USED)) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    assign data     = data_q;
    assign lead_bad = bad_q;

    // R3: bits past the result field never disturb the captured word
    p_tail_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !clr && idx_q == IDX_W'(USED)) |=> $stable(data_q));

endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
    import adcrd_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int GAP_W       = 8,
    parameter int DATA_W      = 12,
    parameter int LEAD_N      = 2,
    parameter int SLEEP_EDGES = 4,
    parameter int TMR_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cmd_sleep,
    input  logic             cmd_wake,
    input  logic [DIV_W-1:0] cfg_half_div,
    input  logic             cfg_len16,
    input  logic [GAP_W-1:0] cfg_gap,
    input  logic             cfg_overwrite,
    input  logic             res_pending,
    input  logic             tmr_exp,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    output logic             csn_o,
    output logic             sclk_o,
    output logic             cap_clr,
    output logic             cap_stb,
    output logic             done_norm,
    output logic             asleep_o,
    output frame_kind_e      kind_o
);

    localparam int SHORT_LEN = LEAD_N + DATA_W;
    localparam int LONG_LEN  = SHORT_LEN + 2;
    localparam int EDGE_W    = $clog2(LONG_LEN + 1);

    rd_state_e   state_q, state_d;
    frame_kind_e kind_q;
    logic [EDGE_W-1:0] target_q, edge_q;
    logic [DIV_W-1:0]  half_q;
    logic [GAP_W-1:0]  gap_q;
    logic              asleep_q;

    logic start_wake, start_sleep, start_norm, start_any, last_edge;

    assign start_wake  = cmd_wake && asleep_q;
    assign start_sleep = cmd_sleep && !asleep_q;
    assign start_norm  = run && !asleep_q && (!res_pending || cfg_overwrite);
    assign start_any   = start_wake || start_sleep || start_norm;
    assign last_edge   = ((edge_q + EDGE_W'(1)) == target_q);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_any) state_d = ST_SETUP;
            ST_SETUP: if (tmr_exp)   state_d = ST_HIGH;
            ST_HIGH:  if (tmr_exp)   state_d = last_edge ? ST_GAP : ST_LOW;
            ST_LOW:   if (tmr_exp)   state_d = ST_HIGH;
            ST_GAP:   if (tmr_exp)   state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        tmr_load  = 1'b0;
        tmr_val   = TMR_W'(half_q);
        cap_clr   = 1'b0;
        cap_stb   = 1'b0;
        done_norm = 1'b0;
        csn_o     = 1'b1;
        sclk_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_any) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(cfg_half_div);
                    cap_clr  = 1'b1;
                end
            end
            ST_SETUP: begin
                csn_o    = 1'b0;
                tmr_load = tmr_exp;
                cap_stb  = tmr_exp;
            end
            ST_HIGH: begin
                csn_o    = 1'b0;
                sclk_o   = 1'b1;
                tmr_load = tmr_exp;
                if (last_edge) tmr_val = TMR_W'(gap_q);
                done_norm = tmr_exp && last_edge && (kind_q == FK_NORMAL);
            end
            ST_LOW: begin
                csn_o    = 1'b0;
                tmr_load = tmr_exp;
                cap_stb  = tmr_exp;
            end
            ST_GAP: begin
                csn_o = 1'b1;
            end
            default: begin
                csn_o = 1'b1;
            end
        endcase
    end

    // frame bookkeeping latched at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q   <= FK_NORMAL;
            target_q <= EDGE_W'(SHORT_LEN);
            edge_q   <= '0;
            half_q   <= DIV_W'(1);
            gap_q    <= GAP_W'(1);
            asleep_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start_any) begin
                half_q <= cfg_half_div;
                gap_q  <= cfg_gap;
                edge_q <= '0;
                if (start_wake) begin
                    kind_q   <= FK_WAKE;
                    target_q <= EDGE_W'(LONG_LEN);
                end else if (start_sleep) begin
                    kind_q   <= FK_SLEEP;
                    target_q <= EDGE_W'(SLEEP_EDGES);
                end else begin
                    kind_q   <= FK_NORMAL;
                    target_q <= cfg_len16 ? EDGE_W'(LONG_LEN) : EDGE_W'(SHORT_LEN);
                end
            end
            if (state_q == ST_HIGH && tmr_exp) begin
                edge_q <= edge_q + EDGE_W'(1);
                if (last_edge && kind_q == FK_SLEEP) asleep_q <= 1'b1;
                if (last_edge && kind_q == FK_WAKE)  asleep_q <= 1'b0;
            end
        end
    end

    assign asleep_o = asleep_q;
    assign kind_o   = kind_q;

    // R2: the falling-edge count never passes the frame target
    p_edge_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_q <= target_q);

    // R2: a normal frame ends on 14 or 16 falling edges
    p_norm_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(csn_o) && kind_q == FK_NORMAL) |->
        (edge_q == EDGE_W'(SHORT_LEN) || edge_q == EDGE_W'(LONG_LEN)));

    // R8: sleep frame released inside the power-down window
    p_sleep_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(csn_o) && kind_q == FK_SLEEP) |->
        (edge_q >= EDGE_W'(2) && edge_q <= EDGE_W'(10)));

    // R10: wake frame is a full dummy frame
    p_wake_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(csn_o) && kind_q == FK_WAKE) |-> (edge_q == EDGE_W'(LONG_LEN)));

    // R9: from sleep only a wake frame may begin
    p_asleep_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(csn_o) && $past(asleep_q)) |-> (kind_q == FK_WAKE));

    // R4: clock stays parked low whenever chip-select is released
    p_sclk_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csn_o) |-> !sclk_o);

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adcrd_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int LEAD_N      = 2,
    parameter int DIV_W       = 8,
    parameter int GAP_W       = 8,
    parameter int SLEEP_EDGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cmd_sleep,
    input  logic              cmd_wake,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic              cfg_len16,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              cfg_overwrite,
    input  logic              adc_sdo,
    output logic              adc_csn,
    output logic              adc_sclk,
    output logic [DATA_W-1:0] res_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic              res_frame_err,
    output logic              asleep
);

    localparam int TMR_W = (DIV_W > GAP_W) ? DIV_W : GAP_W;

    logic              tmr_load, tmr_exp;
    logic [TMR_W-1:0]  tmr_val;
    logic              cap_clr, cap_stb, done_norm;
    logic [DATA_W-1:0] cap_data;
    logic              cap_bad;
    frame_kind_e       kind;

    logic [DATA_W-1:0] data_q;
    logic              valid_q, err_q;

    adcrd_timer #(.W(TMR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .val    (tmr_val),
        .expire (tmr_exp)
    );

    adcrd_capture #(.DATA_W(DATA_W), .LEAD_N(LEAD_N)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cap_clr),
        .stb      (cap_stb),
        .sdi      (adc_sdo),
        .data     (cap_data),
        .lead_bad (cap_bad)
    );

    adcrd_ctrl #(
        .DIV_W       (DIV_W),
        .GAP_W       (GAP_W),
        .DATA_W      (DATA_W),
        .LEAD_N      (LEAD_N),
        .SLEEP_EDGES (SLEEP_EDGES),
        .TMR_W       (TMR_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .cmd_sleep     (cmd_sleep),
        .cmd_wake      (cmd_wake),
        .cfg_half_div  (cfg_half_div),
        .cfg_len16     (cfg_len16),
        .cfg_gap       (cfg_gap),
        .cfg_overwrite (cfg_overwrite),
        .res_pending   (valid_q),
        .tmr_exp       (tmr_exp),
        .tmr_load      (tmr_load),
        .tmr_val       (tmr_val),
        .csn_o         (adc_csn),
        .sclk_o        (adc_sclk),
        .cap_clr       (cap_clr),
        .cap_stb       (cap_stb),
        .done_norm     (done_norm),
        .asleep_o      (asleep),
        .kind_o        (kind)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (done_norm) begin
            data_q  <= cap_data;
            err_q   <= cap_bad;
            valid_q <= 1'b1;
        end else if (valid_q && res_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign res_data      = data_q;
    assign res_valid     = valid_q;
    assign res_frame_err = err_q;

    // R5: valid is held until the consumer takes it
    p_valid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> res_valid);

    // R5: a pending result is not disturbed without overwrite
    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready && !cfg_overwrite) |=>
        ($stable(res_data) && $stable(res_frame_err)));

    // R5: no normal frame starts over a pending result unless overwrite
    p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_csn) |->
        (kind != FK_NORMAL || !$past(res_valid) || $past(cfg_overwrite)));

endmodule

// File: tb/sim_adc_frame_reader.sv
module sim_adc_frame_reader;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0, cmd_sleep = 1'b0, cmd_wake = 1'b0;
    logic [7:0]  cfg_half_div = 8'd1;
    logic        cfg_len16 = 1'b0;
    logic [7:0]  cfg_gap = 8'd1;
    logic        cfg_overwrite = 1'b0;
    logic        adc_sdo = 1'b0;
    logic        adc_csn, adc_sclk;
    logic [11:0] res_data;
    logic        res_valid, res_frame_err, asleep;
    logic        res_ready = 1'b0;

    int n_total = 0, n_bad = 0;
    bit finished = 0;

    // converter model state
    logic [1:0]  m_lead = 2'b00;
    logic [11:0] m_code = 12'h000;
    int bi = 0;
    int n_fall = 0, n_rise = 0, n_frames = 0, ph_bad = 0, cur_h = 1;
    time t_prev = 0, t_rise = 0, t_low0 = 0, t_hi0 = 0;

    adc_frame_reader u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .cmd_sleep(cmd_sleep),
        .cmd_wake(cmd_wake), .cfg_half_div(cfg_half_div), .cfg_len16(cfg_len16),
        .cfg_gap(cfg_gap), .cfg_overwrite(cfg_overwrite), .adc_sdo(adc_sdo),
        .adc_csn(adc_csn), .adc_sclk(adc_sclk), .res_data(res_data),
        .res_valid(res_valid), .res_ready(res_ready),
        .res_frame_err(res_frame_err), .asleep(asleep)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic frame_bit(int i);
        logic [15:0] fv;
        fv = {m_lead, m_code, 2'b00};
        return (i < 16) ? fv[15-i] : 1'b0;
    endfunction

    always @(negedge adc_csn) begin
        bi = 0;
        adc_sdo = frame_bit(0);
        n_fall = 0; n_rise = 0; ph_bad = 0;
        n_frames = n_frames + 1;
        t_prev = $time; t_low0 = $time;
    end

    always @(posedge adc_csn) t_hi0 = $time;

    always @(negedge adc_sclk) begin
        bi = bi + 1;
        adc_sdo = frame_bit(bi);
        n_fall = n_fall + 1;
        if ($time - t_rise != time'(cur_h * CLK_PERIOD)) ph_bad = ph_bad + 1;
        t_prev = $time;
    end

    always @(posedge adc_sclk) begin
        n_rise = n_rise + 1;
        if ($time - t_prev != time'(cur_h * CLK_PERIOD)) ph_bad = ph_bad + 1;
        t_rise = $time;
    end

    task automatic chk(string req, longint act, longint exp);
        n_total++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic clear_result();
        @(negedge clk); res_ready = 1'b1;
        @(negedge clk); res_ready = 1'b0;
        chk("R5 valid cleared by ready", res_valid, 0);
    endtask

    // one normal frame, checked fully
    task automatic one_frame(int h, bit l16, logic [11:0] code, logic [1:0] lead);
        int n;
        time tl;
        n = l16 ? 16 : 14;
        @(negedge clk);
        cfg_half_div = 8'(h); cfg_len16 = l16; cur_h = (h == 0) ? 1 : h;
        m_code = code; m_lead = lead; run = 1'b1;
        @(negedge adc_csn); run = 1'b0;
        @(posedge adc_csn); tl = $time - t_low0;
        @(negedge clk);
        chk("R2 falling edges", n_fall, n);
        chk("R2 rising edges", n_rise, n);
        chk("R2 csn low time", longint'(tl), longint'(2 * n * cur_h * CLK_PERIOD));
        chk("R4 phase lengths", ph_bad, 0);
        chk("R5 valid after frame", res_valid, 1);
        chk("R3 result data", res_data, code);
        chk("R11 framing error", res_frame_err, (lead != 2'b00) ? 1 : 0);
        clear_result();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_total++; n_bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] codes [6];
        int fr0;
        time th;
        codes[0] = 12'h000; codes[1] = 12'hFFF; codes[2] = 12'hA5A;
        codes[3] = 12'h5A5; codes[4] = 12'h001; codes[5] = 12'h800;

        repeat (3) @(negedge clk);
        chk("R1 csn after reset", adc_csn, 1);
        chk("R1 sclk after reset", adc_sclk, 0);
        chk("R1 valid after reset", res_valid, 0);
        chk("R1 asleep after reset", asleep, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 sclk idle low", adc_sclk, 0);

        // sweep: divider x length x code
        for (int h = 0; h <= 3; h++)
            for (int l = 0; l < 2; l++)
                for (int c = 0; c < 6; c++)
                    one_frame(h, l[0], codes[c], 2'b00);

        // R11: each leading bit set
        one_frame(1, 1'b0, 12'h3C3, 2'b10);
        one_frame(2, 1'b1, 12'h0F0, 2'b01);
        one_frame(1, 1'b0, 12'h3C3, 2'b00);

        // R12: configuration change in mid frame is not used
        @(negedge clk);
        cfg_half_div = 8'd2; cfg_len16 = 1'b0; cur_h = 2; m_code = 12'h123;
        m_lead = 2'b00; run = 1'b1;
        @(negedge adc_csn); run = 1'b0;
        repeat (3) @(negedge clk);
        cfg_half_div = 8'd3; cfg_len16 = 1'b1;
        @(posedge adc_csn);
        @(negedge clk);
        chk("R12 edges use latched length", n_fall, 14);
        chk("R12 low time uses latched divider", longint'(t_hi0 - t_low0), longint'(56 * CLK_PERIOD));
        chk("R12 phases use latched divider", ph_bad, 0);
        chk("R12 result", res_data, 12'h123);
        clear_result();

        // R7: gap between continuous frames
        @(negedge clk);
        cfg_half_div = 8'd1; cfg_len16 = 1'b0; cur_h = 1; cfg_gap = 8'd3;
        res_ready = 1'b1; run = 1'b1;
        @(posedge adc_csn); th = $time;
        @(negedge adc_csn);
        chk("R7 csn high time gap=3", longint'($time - th), longint'(4 * CLK_PERIOD));
        @(negedge clk); cfg_gap = 8'd0;
        @(posedge adc_csn); @(posedge adc_csn); th = $time;
        @(negedge adc_csn);
        chk("R7 csn high time gap=0", longint'($time - th), longint'(2 * CLK_PERIOD));
        run = 1'b0;
        @(posedge adc_csn);
        repeat (4) @(negedge clk);
        res_ready = 1'b0;
        chk("R5 valid taken in stream", res_valid, 0);

        // R5: pending result blocks further frames
        @(negedge clk);
        m_code = 12'h6B2; run = 1'b1;
        @(posedge adc_csn);
        @(negedge clk);
        m_code = 12'h1D9; fr0 = n_frames;
        repeat (300) @(negedge clk);
        chk("R5 no frame while pending", n_frames, fr0);
        chk("R5 valid held", res_valid, 1);
        chk("R5 data held", res_data, 12'h6B2);
        res_ready = 1'b1;
        @(negedge clk); res_ready = 1'b0;
        @(posedge adc_csn); run = 1'b0;
        @(negedge clk);
        chk("R5 next frame after ready", res_data, 12'h1D9);
        clear_result();

        // R6: overwrite keeps frames running
        @(negedge clk);
        cfg_overwrite = 1'b1; m_code = 12'h111; run = 1'b1;
        @(posedge adc_csn); @(negedge clk); m_code = 12'h222;
        @(posedge adc_csn); @(negedge clk); m_code = 12'h333;
        @(posedge adc_csn); run = 1'b0;
        @(negedge clk);
        chk("R6 newest result kept", res_data, 12'h333);
        chk("R6 valid stays high", res_valid, 1);
        repeat (10) @(negedge clk);
        cfg_overwrite = 1'b0;
        clear_result();

        // R8: sleep frame
        @(negedge clk);
        cmd_sleep = 1'b1;
        @(negedge adc_csn); cmd_sleep = 1'b0;
        @(posedge adc_csn);
        @(negedge clk);
        chk("R8 sleep falling edges", n_fall, 4);
        chk("R8 sleep gives no result", res_valid, 0);
        chk("R8 asleep set", asleep, 1);

        // R9: asleep ignores run and sleep
        fr0 = n_frames;
        run = 1'b1; cmd_sleep = 1'b1;
        repeat (300) @(negedge clk);
        chk("R9 no frame while asleep", n_frames, fr0);
        chk("R9 still asleep", asleep, 1);
        chk("R9 no result while asleep", res_valid, 0);
        run = 1'b0; cmd_sleep = 1'b0;

        // R10: wake frame
        @(negedge clk);
        cmd_wake = 1'b1;
        @(negedge adc_csn); cmd_wake = 1'b0;
        @(posedge adc_csn);
        @(negedge clk);
        chk("R10 wake falling edges", n_fall, 16);
        chk("R10 wake gives no result", res_valid, 0);
        chk("R10 asleep cleared", asleep, 0);
        repeat (4) @(negedge clk);
        one_frame(1, 1'b1, 12'h9E7, 2'b00);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule